// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Fetch Sequencer

This block answers a maskable interrupt request on behalf of the core. When a request is present and interrupts are enabled, it runs two acknowledge bus cycles toward an external priority interrupt controller. Each cycle uses the same T1, T2, T3, optional TW and T4 states as a read, with an active-low acknowledge strobe where the read strobe would be. Throughout the sequence it tells the bus unit to keep the address lines at their last value instead of driving a new address.

The first acknowledge cycle only alerts the controller, so whatever is on the data lines then is discarded. In the second cycle the low data byte carries the interrupt type. The block latches it and presents the type times four as a pointer into the vector table, together with a one-cycle valid pulse. Between the two cycles the strobe goes high and the bus spends at least one idle state. A new request is not looked at again until the pointer has been delivered.

Top module: `inta_seq`

## Requirements
- R1: During and right after reset `inta_n` is 1, `addr_hold` is 0 and `vec_valid` is 0.
- R2: A sequence starts only from idle with `irq_req` and `irq_en` both 1; with `irq_en` at 0 a pending request leaves `inta_n` at 1 and `addr_hold` at 0.
- R3: Each accepted request produces exactly two low pulses on `inta_n`. Each pulse covers T2, T3 and every TW, so it is 2 cycles long when `ready` is 1.
- R4: `ready` is sampled at the end of T3 and of each TW. Every edge that finds it at 0 adds one TW, so a cycle with W waits has an `inta_n` pulse of 2+W cycles.
- R5: Between the two pulses `inta_n` stays 1 for GAP_STATES+2 cycles: T4, GAP_STATES idle states, then T1.
- R6: `addr_hold` is 1 from the first T1 through the second T4, including the gap, and it is 1 whenever `inta_n` is 0.
- R7: Data on `dbus_lo` during the first cycle is ignored. The type is the `dbus_lo` value at the clock edge that ends the second cycle's T3 or TW with `ready` at 1.
- R8: `vec_ptr` equals the type shifted left by two (`{type,2'b00}`). `vec_valid` is 1 for exactly one cycle, the cycle after the second T4, and `vec_ptr` holds its value afterwards.
- R9: A request held high is not sampled again until the pointer has been delivered. After the `vec_valid` cycle one idle cycle follows with `addr_hold` at 0, and then a new sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Maskable interrupt request level |
| irq_en | input | 1 | Interrupt enable |
| ready | input | 1 | Bus ready; 0 inserts wait states |
| dbus_lo | input | TYPE_W | Low data byte from the interrupt controller |
| inta_n | output | 1 | Active-low acknowledge strobe |
| addr_hold | output | 1 | Keep the address bus at its last value |
| vec_ptr | output | TYPE_W+2 | Vector table pointer, type times four |
| vec_valid | output | 1 | One-cycle pulse marking a new pointer |

## Verification
The bench models the interrupt controller. In the first cycle it drives a decoy byte, and it gives the two cycles different wait counts. A design that latched in the wrong cycle, or one edge early or late, returns the decoy or a stale type. A design that sampled `ready` at the wrong state returns pulses of the wrong length. The inter-pulse gap and the per-request pulse count are measured to catch missing idle states or a third acknowledge. A request held across two deliveries checks that it is not sampled again early. A request with the enable low checks that the bus stays quiet. Type values 0x00 and 0xFF check that no pointer bits are dropped.

// File: rtl/inta_seq.sv
module inta_seq #(
  parameter int TYPE_W     = 8,
  parameter int GAP_STATES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              irq_en,
  input  logic              ready,
  input  logic [TYPE_W-1:0] dbus_lo,
  output logic              inta_n,
  output logic              addr_hold,
  output logic [TYPE_W+1:0] vec_ptr,
  output logic              vec_valid
);
  localparam int GAP_W = (GAP_STATES > 1) ? $clog2(GAP_STATES) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_STATES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4, S_GAP, S_DONE
  } st_t;

  st_t              st, st_nx;
  logic             second;
  logic [GAP_W-1:0] gcnt;
  logic [TYPE_W-1:0] type_q;

  wire data_edge = (st == S_T3 || st == S_TW) && ready;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (irq_req && irq_en) st_nx = S_T1;
      S_T1:   st_nx = S_T2;
      S_T2:   st_nx = S_T3;
      S_T3,
      S_TW:   st_nx = ready ? S_T4 : S_TW;
      S_T4:   st_nx = second ? S_DONE : S_GAP;
      S_GAP:  if (gcnt == GAP_LAST) st_nx = S_T1;
      S_DONE: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      second <= 1'b0;
      gcnt   <= '0;
      type_q <= '0;
    end else begin
      st <= st_nx;
      if (st == S_T4 && !second) second <= 1'b1;
      else if (st == S_DONE)     second <= 1'b0;
      if (st == S_GAP) gcnt <= gcnt + 1'b1;
      else             gcnt <= '0;
      if (data_edge && second) type_q <= dbus_lo;
    end
  end

  assign inta_n    = !(st == S_T2 || st == S_T3 || st == S_TW);
  assign addr_hold = (st != S_IDLE) && (st != S_DONE);
  assign vec_valid = (st == S_DONE);
  assign vec_ptr   = {type_q, 2'b00};

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_hold) |-> $past(irq_req && irq_en));
  // R4
  wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_T3 || st == S_TW) && !ready) |=> (st == S_TW && !inta_n));
  // R5
  gap_after_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T4 && !second) |=> (st == S_GAP && inta_n && addr_hold));
  // R6
  hold_during_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n |-> addr_hold);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> (!vec_valid && $stable(vec_ptr)));
  // R9
  no_resample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !addr_hold);
endmodule

// File: tb/inta_seq_bench.sv
module inta_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 1;

  logic clk = 0, rst_n = 0;
  logic irq_req = 0, irq_en = 0, ready = 1;
  logic [7:0] dbus_lo = 8'h00;
  logic inta_n, addr_hold, vec_valid;
  logic [9:0] vec_ptr;

  int tests = 0, fails = 0;
  bit finished = 0;

  int q_ptr[$], q_l1[$], q_l2[$];
  int cur_w1 = 0, cur_w2 = 0;
  logic [7:0] cur_type = 0, cur_junk = 0;

  int pulses = 0, phase = 0, lo_len = 0, hi_len = 0, gap_seen = 0;
  int lens[4];
  bit prev_inta = 1, hold_err = 0, after_valid = 0;

  inta_seq #(.TYPE_W(8), .GAP_STATES(GAP)) u_inta_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .ready(ready), .dbus_lo(dbus_lo), .inta_n(inta_n),
    .addr_hold(addr_hold), .vec_ptr(vec_ptr), .vec_valid(vec_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // controller model and monitor
  always @(negedge clk) if (rst_n) begin
    if (after_valid) begin
      check("R9 idle after delivery", addr_hold, 0);
      after_valid = 0;
    end
    if (!inta_n) begin
      if (prev_inta) begin
        pulses++;
        phase = 1;
        if (pulses == 2) gap_seen = hi_len;
      end else phase++;
      lo_len++;
      if (!addr_hold) hold_err = 1;
      ready = !(phase >= 2 && phase < 2 + ((pulses == 1) ? cur_w1 : cur_w2));
      dbus_lo = (pulses == 2) ? cur_type : cur_junk;
    end else begin
      if (!prev_inta) begin
        if (pulses >= 1 && pulses <= 4) lens[pulses-1] = lo_len;
        lo_len = 0;
        hi_len = 1;
      end else hi_len++;
      if (pulses == 1 && !addr_hold) hold_err = 1;
      phase = 0;
      ready = 1;
      dbus_lo = cur_junk;
    end
    prev_inta = inta_n;
    if (vec_valid) begin
      if (q_ptr.size() == 0) check("R8 unexpected vector", 1, 0);
      else begin
        check("R7 R8 pointer", vec_ptr, q_ptr.pop_front());
        check("R3 pulse count", pulses, 2);
        check("R3 R4 first strobe length", lens[0], q_l1.pop_front());
        check("R3 R4 second strobe length", lens[1], q_l2.pop_front());
        check("R5 gap length", gap_seen, GAP + 2);
        check("R6 address held", hold_err, 0);
      end
      pulses = 0; hold_err = 0; after_valid = 1;
    end
  end

  task automatic push_exp(input logic [7:0] t, input int w1, input int w2);
    q_ptr.push_back({t, 2'b00});
    q_l1.push_back(2 + w1);
    q_l2.push_back(2 + w2);
  endtask

  task automatic do_irq(input logic [7:0] t, input logic [7:0] junk,
                        input int w1, input int w2);
    cur_type = t; cur_junk = junk; cur_w1 = w1; cur_w2 = w2;
    push_exp(t, w1, w2);
    @(negedge clk) irq_req = 1;
    do @(negedge clk); while (!vec_valid);
    irq_req = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    irq_en = 1;
    repeat (3) @(negedge clk);
    // R1
    check("R1 inta_n reset", inta_n, 1);
    check("R1 addr_hold reset", addr_hold, 0);
    check("R1 vec_valid reset", vec_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", {inta_n, addr_hold, vec_valid}, 3'b100);

    // R7 R8 basic types, decoy data in cycle one
    do_irq(8'h08, 8'hAA, 0, 0);
    do_irq(8'h00, 8'hFF, 0, 0);
    do_irq(8'hFF, 8'h00, 0, 0);
    // R4 wait states in each cycle
    do_irq(8'h5A, 8'hC3, 2, 0);
    do_irq(8'h21, 8'h77, 0, 3);
    do_irq(8'h9C, 8'h11, 1, 4);

    // R2 enable low blocks the request
    begin
      int bad = 0;
      irq_en = 0;
      @(negedge clk) irq_req = 1;
      repeat (20) @(negedge clk) if (!inta_n || addr_hold) bad++;
      check("R2 masked request ignored", bad, 0);
      irq_req = 0; irq_en = 1;
      repeat (2) @(negedge clk);
    end

    // R9 request held across two deliveries
    cur_type = 8'h3E; cur_junk = 8'h41; cur_w1 = 1; cur_w2 = 1;
    push_exp(8'h3E, 1, 1);
    push_exp(8'h3E, 1, 1);
    @(negedge clk) irq_req = 1;
    do @(negedge clk); while (!vec_valid);
    @(negedge clk);
    do @(negedge clk); while (!vec_valid);
    irq_req = 0;
    repeat (4) @(negedge clk);
    check("R9 all vectors delivered", q_ptr.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule